// File: doc/BRIEF.md
# Adaptive Delay-Test Session Sequencer

This block steers path-delay testing of a linear pipeline made of `NUM_STAGES` logic stages. The stages are separated by `NUM_STAGES+1` groups of `GRP_W` latches. Group 0 feeds the first stage, group `b` sits between stage `b-1` and stage `b`, and group `NUM_STAGES` takes the last stage's outputs. For each test session the sequencer chooses a contiguous span of stages, called the sub-circuit, and drives a 2-bit mode code to every latch. An external tester then applies vectors and compares responses. At the end of the session the tester returns one fail flag per latch of the span's output group.

The first session covers the first stage alone. An output latch that reports a failure has borrowed time from the following stage. It is marked, and the next session widens the current span by one stage downstream. In that session every marked boundary latch is left transparent and every unmarked one reloads test data. A session with no failure moves on to the next stage as a fresh one-stage span. The sweep ends once the last stage has been inside a passing session. An optional opening session covers the whole pipeline, launching on the rising edge and capturing on the falling edge. A failure in it is a delay fault that no borrowing can absorb, and the sweep ends there.

Top module: `borrow_sweep_ctrl`

## Requirements
- R1: After reset `done`, `delay_fault` and `session_start` are 0 and `sess_count` is 0. Group 0 is in scan-in, group `NUM_STAGES` is in rising capture and every inner group is normal. Mode codes: normal=2'b00, scan-in=2'b01, rising capture=2'b10, falling capture=2'b11. The code of latch j of group g sits at bits `[(g*GRP_W+j)*2 +: 2]` of `latch_mode`.
- R2: `start` clears all borrow marks, `done`, `delay_fault` and `sess_count`. Without `rf_en` the first session covers stage 0 alone, with group 0 in scan-in, group 1 in rising capture, and all other inner groups normal.
- R3: Each session is announced by a one-cycle `session_start` pulse. `latch_mode` is stable from that pulse until `session_done`. `sess_count` increases by one for every accepted `session_done`, and there is exactly one `session_start` per counted session.
- R4: In a rising-capture session, each output-group latch whose `fail_vec` bit is 1 becomes a borrow mark. In that case the next span keeps its first stage and adds the following stage. Inside the span, marked boundary latches are normal and unmarked ones are scan-in.
- R5: A rising-capture session with `fail_vec` all zero is followed by a one-stage span on the next stage. That span's input group is in scan-in.
- R6: When the session ending at the last stage returns all zeros, `done` rises with `delay_fault` at 0. `done` then holds until the next `start`.
- R7: With `rf_en` at 1 when `start` is taken, the first session spans the whole pipeline: group 0 scan-in, all inner groups normal, last group falling capture. Any fail bit in that session sets `delay_fault` and `done`, and no further session runs.
- R8: A fail bit from the last group in a rising-capture session sets `delay_fault` and `done`, since the pipeline's outputs cannot borrow.
- R9: Group 0 is never anything but scan-in, and the last group is never normal, in any state.
- R10: Borrow marks persist until the next `start`. Earlier marked boundaries inside a widened span therefore stay normal in every later session of that span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new sweep (taken when idle or finished) |
| rf_en | input | 1 | Run the whole-pipeline falling-capture session first |
| session_done | input | 1 | Tester finished the current session |
| fail_vec | input | GRP_W | Per-latch fail flags of the session's output group, valid with `session_done` |
| session_start | output | 1 | One-cycle pulse: modes are set, session may begin |
| latch_mode | output | (NUM_STAGES+1)*GRP_W*2 | Mode code of every latch |
| sess_count | output | $clog2(NUM_STAGES+2) | Number of sessions completed in this sweep |
| done | output | 1 | Sweep finished |
| delay_fault | output | 1 | Sweep ended on an uncompensable delay fault |

## Verification
In one evaluation step the sequencer both records new borrow marks and chooses the next span. The session that follows therefore depends on a mark write and a span change landing at the same clock edge. The bench provokes this with fail patterns at successive boundaries, so that a span widens several times and old and new marks appear in one mode vector. A reference model predicts every mode vector, and each one is compared at its `session_start`. A second overlap arises on the final stage, where the fault decision and the end of the sweep occur together. It is judged by running a clean last stage and a failing last stage, and checking `done`, `delay_fault` and the session count for each.

// File: rtl/borrow_sweep_pkg.sv
package borrow_sweep_pkg;

  typedef enum logic [1:0] {
    LM_NORMAL = 2'b00,
    LM_SCAN   = 2'b01,
    LM_CAPR   = 2'b10,
    LM_CAPF   = 2'b11
  } lmode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPT_RF,
    ST_CONFIG,
    ST_RUN,
    ST_EVAL,
    ST_DONE
  } sweep_st_t;

  typedef enum logic [1:0] {
    PH_REST,
    PH_RF,
    PH_RR
  } phase_t;

endpackage

// File: rtl/borrow_mark_store.sv
module borrow_mark_store #(
  parameter int NUM_STAGES = 4,
  parameter int GRP_W      = 2,
  localparam int IDX_W     = $clog2(NUM_STAGES + 1),
  localparam int MK_W      = (NUM_STAGES + 1) * GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [GRP_W-1:0] wr_bits,
  output logic [MK_W-1:0]  marks
);

  for (genvar b = 0; b <= NUM_STAGES; b++) begin : g_bnd
    localparam logic [IDX_W-1:0] BI = IDX_W'(b);
    logic             hit;
    logic [GRP_W-1:0] mk_q;
    logic [GRP_W-1:0] mk_d;
    logic             mk_en;

    assign hit   = wr_en && (wr_idx == BI);
    assign mk_en = clr || hit;
    assign mk_d  = clr ? '0 : wr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mk_q <= '0;
      end else if (mk_en) begin
        mk_q <= mk_d;
      end
    end

    assign marks[b*GRP_W +: GRP_W] = mk_q;
  end

  // R10: marks change only on a clear or a write
  a_r10_marks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_en) |=> $stable(marks));

endmodule

// File: rtl/latch_mode_map.sv
module latch_mode_map
  import borrow_sweep_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int GRP_W      = 2,
  localparam int IDX_W     = $clog2(NUM_STAGES + 1),
  localparam int MK_W      = (NUM_STAGES + 1) * GRP_W,
  localparam int MODE_W    = MK_W * 2
) (
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  span_lo,
  input  logic [IDX_W-1:0]  span_hi,
  input  logic [MK_W-1:0]   marks,
  output logic [MODE_W-1:0] latch_mode
);

  logic [IDX_W-1:0] out_grp;
  assign out_grp = span_hi + IDX_W'(1);

  for (genvar g = 0; g <= NUM_STAGES; g++) begin : g_grp
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    for (genvar j = 0; j < GRP_W; j++) begin : g_lat
      lmode_t code;
      if (g == 0) begin : g_pin
        assign code = LM_SCAN;
      end else if (g == NUM_STAGES) begin : g_pout
        assign code = (phase == PH_RF) ? LM_CAPF : LM_CAPR;
      end else begin : g_inner
        always_comb begin
          code = LM_NORMAL;
          if (phase == PH_RR) begin
            if (GI == span_lo) begin
              code = LM_SCAN;
            end else if (GI == out_grp) begin
              code = LM_CAPR;
            end else if ((GI > span_lo) && (GI <= span_hi)) begin
              code = marks[g*GRP_W + j] ? LM_NORMAL : LM_SCAN;
            end
          end
        end
      end
      assign latch_mode[(g*GRP_W + j)*2 +: 2] = code;
    end
  end

endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import borrow_sweep_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int GRP_W      = 2,
  localparam int IDX_W     = $clog2(NUM_STAGES + 1),
  localparam int CNT_W     = $clog2(NUM_STAGES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rf_en,
  input  logic             session_done,
  input  logic [GRP_W-1:0] fail_vec,
  output phase_t           phase,
  output logic [IDX_W-1:0] span_lo,
  output logic [IDX_W-1:0] span_hi,
  output logic             mk_clr,
  output logic             mk_wr,
  output logic [IDX_W-1:0] mk_idx,
  output logic [GRP_W-1:0] mk_bits,
  output logic             in_session,
  output logic             session_start,
  output logic [CNT_W-1:0] sess_count,
  output logic             done,
  output logic             delay_fault
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STAGES - 1);

  sweep_st_t        st_q, st_d;
  logic [IDX_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [GRP_W-1:0] fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             launch_q, launch_d;
  logic             done_q, done_d;
  logic             flt_q, flt_d;

  always_comb begin
    st_d     = st_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    fail_d   = fail_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    flt_d    = flt_q;
    launch_d = 1'b0;
    mk_clr   = 1'b0;
    mk_wr    = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          mk_clr = 1'b1;
          lo_d   = '0;
          hi_d   = '0;
          cnt_d  = '0;
          done_d = 1'b0;
          flt_d  = 1'b0;
          if (rf_en) begin
            st_d     = ST_OPT_RF;
            launch_d = 1'b1;
          end else begin
            st_d = ST_CONFIG;
          end
        end
      end
      ST_OPT_RF: begin
        if (session_done) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (|fail_vec) begin
            flt_d  = 1'b1;
            done_d = 1'b1;
            st_d   = ST_DONE;
          end else begin
            st_d = ST_CONFIG;
          end
        end
      end
      ST_CONFIG: begin
        st_d     = ST_RUN;
        launch_d = 1'b1;
      end
      ST_RUN: begin
        if (session_done) begin
          fail_d = fail_vec;
          cnt_d  = cnt_q + CNT_W'(1);
          st_d   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (hi_q == LAST) begin
          done_d = 1'b1;
          flt_d  = |fail_q;
          st_d   = ST_DONE;
        end else begin
          mk_wr = 1'b1;
          hi_d  = hi_q + IDX_W'(1);
          if (!(|fail_q)) begin
            lo_d = hi_q + IDX_W'(1);
          end
          st_d = ST_CONFIG;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lo_q     <= '0;
      hi_q     <= '0;
      fail_q   <= '0;
      cnt_q    <= '0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      flt_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      fail_q   <= fail_d;
      cnt_q    <= cnt_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      flt_q    <= flt_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_OPT_RF:                    phase = PH_RF;
      ST_CONFIG, ST_RUN, ST_EVAL:   phase = PH_RR;
      default:                      phase = PH_REST;
    endcase
  end

  assign span_lo       = lo_q;
  assign span_hi       = hi_q;
  assign mk_idx        = hi_q + IDX_W'(1);
  assign mk_bits       = fail_q;
  assign in_session    = (st_q == ST_RUN) || (st_q == ST_OPT_RF);
  assign session_start = launch_q;
  assign sess_count    = cnt_q;
  assign done          = done_q;
  assign delay_fault   = flt_q;

  // R3: the launch indication lasts one cycle
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    session_start |=> !session_start);

  // R3: each accepted completion bumps the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_session && session_done) |=> (sess_count == $past(sess_count) + CNT_W'(1)));

  // R4 / R5: every non-final evaluation moves the span end one stage on
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL && hi_q != LAST) |=> (span_hi == $past(span_hi) + IDX_W'(1)));

  // R4: a failing evaluation keeps the span start
  a_r4_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL && hi_q != LAST && |fail_q) |=> $stable(span_lo));

  // R7: a failing falling-capture pass ends the sweep with a fault
  a_r7_rf_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPT_RF && session_done && |fail_vec) |=> (done && delay_fault));

  // R8: the fault flag never appears without completion
  a_r8_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
    delay_fault |-> done);

  // R6: done holds until a new start
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  always_comb begin
    if (rst_n) begin
      a_r5_span_order: assert (lo_q <= hi_q && hi_q <= LAST);
    end
  end

endmodule

// File: rtl/borrow_sweep_ctrl.sv
module borrow_sweep_ctrl
  import borrow_sweep_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int GRP_W      = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic                                   rf_en,
  input  logic                                   session_done,
  input  logic [GRP_W-1:0]                       fail_vec,
  output logic                                   session_start,
  output logic [(NUM_STAGES+1)*GRP_W*2-1:0]      latch_mode,
  output logic [$clog2(NUM_STAGES+2)-1:0]        sess_count,
  output logic                                   done,
  output logic                                   delay_fault
);

  localparam int IDX_W = $clog2(NUM_STAGES + 1);
  localparam int MK_W  = (NUM_STAGES + 1) * GRP_W;

  logic             rs_meta, rs_sync;
  phase_t           phase;
  logic [IDX_W-1:0] span_lo, span_hi, mk_idx;
  logic             mk_clr, mk_wr, in_session;
  logic [GRP_W-1:0] mk_bits;
  logic [MK_W-1:0]  marks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  sweep_sequencer #(.NUM_STAGES(NUM_STAGES), .GRP_W(GRP_W)) u_seq (
    .clk           (clk),
    .rst_n         (rs_sync),
    .start         (start),
    .rf_en         (rf_en),
    .session_done  (session_done),
    .fail_vec      (fail_vec),
    .phase         (phase),
    .span_lo       (span_lo),
    .span_hi       (span_hi),
    .mk_clr        (mk_clr),
    .mk_wr         (mk_wr),
    .mk_idx        (mk_idx),
    .mk_bits       (mk_bits),
    .in_session    (in_session),
    .session_start (session_start),
    .sess_count    (sess_count),
    .done          (done),
    .delay_fault   (delay_fault)
  );

  borrow_mark_store #(.NUM_STAGES(NUM_STAGES), .GRP_W(GRP_W)) u_marks (
    .clk     (clk),
    .rst_n   (rs_sync),
    .clr     (mk_clr),
    .wr_en   (mk_wr),
    .wr_idx  (mk_idx),
    .wr_bits (mk_bits),
    .marks   (marks)
  );

  latch_mode_map #(.NUM_STAGES(NUM_STAGES), .GRP_W(GRP_W)) u_map (
    .phase      (phase),
    .span_lo    (span_lo),
    .span_hi    (span_hi),
    .marks      (marks),
    .latch_mode (latch_mode)
  );

  // R3: modes are frozen while a session is in progress
  a_r3_modes_stable: assert property (@(posedge clk) disable iff (!rs_sync)
    (in_session && $past(in_session)) |-> $stable(latch_mode));

  // R9: the first latch of the last group never becomes transparent
  a_r9_out_not_normal: assert property (@(posedge clk) disable iff (!rs_sync)
    latch_mode[NUM_STAGES*GRP_W*2 +: 2] != LM_NORMAL);

endmodule

// File: tb/sim_borrow_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_borrow_sweep_ctrl;
  localparam int N  = 4;
  localparam int W  = 2;
  localparam int MW = (N + 1) * W * 2;
  localparam int CW = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n, start, rf_en, session_done;
  logic [W-1:0]  fail_vec;
  logic          session_start, done, delay_fault;
  logic [MW-1:0] latch_mode;
  logic [CW-1:0] sess_count;

  always #2 clk = ~clk;

  borrow_sweep_ctrl #(.NUM_STAGES(N), .GRP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rf_en(rf_en),
    .session_done(session_done), .fail_vec(fail_vec),
    .session_start(session_start), .latch_mode(latch_mode),
    .sess_count(sess_count), .done(done), .delay_fault(delay_fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [MW-1:0] q_mode [$];
  logic [W-1:0]  q_fail [$];
  string         q_tag  [$];
  logic [W-1:0]  pat   [0:N];
  logic [W-1:0]  bor_m [0:N];

  // ph: 0 rest, 1 falling-capture pass, 2 rising-capture span lo..hi
  function automatic logic [MW-1:0] mk_mode(int ph, int lo, int hi);
    logic [MW-1:0] v;
    logic [1:0]    c;
    v = '0;
    for (int g = 0; g <= N; g++) begin
      for (int j = 0; j < W; j++) begin
        c = 2'b00;
        if (g == 0) c = 2'b01;
        else if (g == N) c = (ph == 1) ? 2'b11 : 2'b10;
        else if (ph == 2) begin
          if (g == lo) c = 2'b01;
          else if (g == hi + 1) c = 2'b10;
          else if (g > lo && g <= hi) c = bor_m[g][j] ? 2'b00 : 2'b01;
        end
        v[(g*W + j)*2 +: 2] = c;
      end
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor / tester responder: pops expected modes, answers with fail flags
  initial begin
    logic [MW-1:0] m;
    logic [W-1:0]  f;
    string         t;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && session_start === 1'b1) begin
        if (q_mode.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL R3 unexpected session_start act=1 exp=0");
        end else begin
          m = q_mode.pop_front();
          f = q_fail.pop_front();
          t = q_tag.pop_front();
          chk(t, 64'(latch_mode), 64'(m));
          repeat (2) @(negedge clk);
          session_done = 1'b1;
          fail_vec     = f;
          @(negedge clk);
          session_done = 1'b0;
          fail_vec     = '0;
        end
      end
    end
  end

  // driver: builds the expected session list, then launches the sweep
  task automatic run_case(string name, bit rf, bit rf_fail, bit out_fail);
    int lo, hi, cnt;
    bit flt;
    logic [W-1:0] f;
    for (int i = 0; i <= N; i++) bor_m[i] = '0;
    lo = 0; hi = 0; cnt = 0; flt = 0;
    if (rf) begin
      q_mode.push_back(mk_mode(1, 0, 0));
      q_fail.push_back(rf_fail ? '1 : '0);
      q_tag.push_back($sformatf("R7 %s falling-capture pass modes", name));
      cnt++;
      flt = rf_fail;
    end
    if (!flt) begin
      while (1) begin
        f = (hi + 1 == N) ? (out_fail ? '1 : '0) : pat[hi + 1];
        q_mode.push_back(mk_mode(2, lo, hi));
        q_fail.push_back(f);
        q_tag.push_back((cnt == 0 || (rf && cnt == 1)) ?
          $sformatf("R2 %s first span modes", name) :
          $sformatf("R4 R5 R10 %s span %0d..%0d modes", name, lo, hi));
        cnt++;
        if (hi == N - 1) begin
          flt = |f;
          break;
        end
        bor_m[hi + 1] = f;
        if (|f) hi++;
        else begin
          lo = hi + 1;
          hi = hi + 1;
        end
      end
    end
    @(negedge clk);
    start = 1'b1;
    rf_en = rf;
    @(negedge clk);
    start = 1'b0;
    rf_en = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk($sformatf("R3 %s session count", name), 64'(sess_count), 64'(cnt));
    chk($sformatf("R6 R7 R8 %s fault flag", name), 64'(delay_fault), 64'(flt));
    chk($sformatf("R3 %s all sessions launched", name), 64'(q_mode.size()), 64'd0);
    repeat (4) @(negedge clk);
    chk($sformatf("R6 %s done held", name), 64'(done), 64'd1);
    chk($sformatf("R9 %s rest modes", name), 64'(latch_mode), 64'(mk_mode(0, 0, 0)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R6 watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rf_en = 1'b0;
    session_done = 1'b0; fail_vec = '0;
    for (int i = 0; i <= N; i++) begin pat[i] = '0; bor_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 fault after reset", 64'(delay_fault), 64'd0);
    chk("R1 session_start after reset", 64'(session_start), 64'd0);
    chk("R1 count after reset", 64'(sess_count), 64'd0);
    chk("R1 modes after reset", 64'(latch_mode), 64'(mk_mode(0, 0, 0)));

    run_case("clean", 1'b0, 1'b0, 1'b0);

    pat[1] = 2'b01;
    run_case("borrow_b1", 1'b0, 1'b0, 1'b0);

    pat[1] = 2'b11; pat[2] = 2'b10; pat[3] = 2'b00;
    run_case("chain_b1_b2", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i <= N; i++) pat[i] = '0;
    run_case("restart_clears", 1'b0, 1'b0, 1'b0);

    run_case("rf_pass", 1'b1, 1'b0, 1'b0);
    run_case("rf_fail", 1'b1, 1'b1, 1'b0);
    run_case("out_fault", 1'b0, 1'b0, 1'b1);

    pat[1] = 2'b10; pat[2] = 2'b01; pat[3] = 2'b11;
    run_case("borrow_to_end", 1'b1, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule